// File: doc/BRIEF.md
# DDR Read Capture with System-Clock Polarity Selection

This block receives read data that arrives with a double-data-rate source strobe and moves it into the system clock domain. Each data line is sampled on both edges of an already-delayed strobe. The bit taken on the rising edge is held for another half strobe cycle so that it lines up with the bit taken on the following falling edge. The two bits then cross into the system domain as one pair.

The edge that performs the crossing is chosen once per reset. On the first rising edge of the preamble-detect input, the block records the level of the system clock. A low level keeps the system clock as it is. A high level selects the inverted clock for every register on the receiving side. A static mode input sets the transfer depth. In half mode the aligned pair goes straight into the output registers. In full mode one more system-side stage sits in front of them.

A data-valid output marks each pair that was captured while preamble-detect was high. It drops once the pipeline has drained after the strobe stops or the window closes.

Top module: `ddr_rd_capture`

## Requirements
- R1: While rst_ni is low, and after its release until the first strobe edge, q_rise_o, q_fall_o, pol_o and valid_o are all 0.
- R2: Each output pair carries the bit sampled on a strobe rising edge in q_rise_o and the bit sampled on the next strobe falling edge in q_fall_o. For a serial stream sent most significant bit first, the pairs come out in sending order with no pair lost, repeated or swapped.
- R3: Each strobe falling edge completes exactly one pair, and each completed pair is presented exactly once at the outputs.
- R4: pol_o takes the level of clk_i at the first rising edge of preamble_i after reset: 1 if clk_i was high, 0 if it was low.
- R5: After the first preamble_i rising edge, later preamble_i edges leave pol_o unchanged until the next reset.
- R6: The outputs change only on the rising edge of clk_i when pol_o is 0, and only on the falling edge of clk_i when pol_o is 1. They hold their values across the other edge.
- R7: With full_mode_i = 0, a pair appears at the first transfer edge after the strobe falling edge that completes it. With full_mode_i = 1, it appears exactly one transfer edge later.
- R8: valid_o is 1 only for pairs whose falling edge found preamble_i high. A pair captured while preamble_i is low, such as a postamble strobe cycle, is not flagged. valid_o returns to 0 one transfer edge after the last flagged pair once the strobe stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dqs_i | input | 1 | Delayed read strobe, centred in the data eye |
| dq_i | input | DQ_W | Read data lines |
| preamble_i | input | 1 | Preamble-detect, high across the read window |
| full_mode_i | input | 1 | 0 = half-cycle transfer, 1 = full-cycle transfer; static during a read |
| q_rise_o | output | DQ_W | Bit of the pair captured on the strobe rising edge |
| q_fall_o | output | DQ_W | Bit of the pair captured on the strobe falling edge |
| pol_o | output | 1 | 1 when the inverted system clock performs the transfer |
| valid_o | output | 1 | Output pair is part of the read window |

## Verification
The strobe-to-clock phase is swept across all four quarter-cycle positions, so both polarity outcomes occur. A design that sampled the clock level wrongly, or crossed on the wrong clock edge, would show outputs moving on the unexpected edge or a wrong pol_o. Half and full mode are run at the same phase and their first-valid positions are compared, which exposes a missing or doubled extra stage. Each burst ends with a postamble cycle outside the window, and a miscounted or late-clearing valid would show as seventeen flagged pairs or valid stuck high. A second preamble edge at the opposite clock level catches a polarity latch that is not sticky.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  typedef enum logic {
    XFER_HALF = 1'b0,
    XFER_FULL = 1'b1
  } xfer_mode_e;

  localparam int unsigned DQ_W_DEF = 1;
endpackage

// File: rtl/ddr_pol_detect.sv
module ddr_pol_detect (
  input  logic preamble_i,
  input  logic clk_i,
  input  logic rst_ni,
  output logic pol_o
);
  logic seen_q;
  logic pol_q;

  // clk_i is sampled as data: its level at the first window edge picks the hand-off edge
  always_ff @(posedge preamble_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (!seen_q) begin
      seen_q <= 1'b1;
      pol_q  <= clk_i;
    end
  end

  assign pol_o = pol_q;
endmodule

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int unsigned DQ_W = 1
) (
  input  logic            dqs_i,
  input  logic            rst_ni,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            preamble_i,
  output logic [DQ_W-1:0] rise_o,
  output logic [DQ_W-1:0] fall_o,
  output logic            vld_o,
  output logic            tog_o
);
  logic vld_q;
  logic tog_q;

  for (genvar g = 0; g < DQ_W; g++) begin : g_bit
    logic pos_q;
    logic neg_q;
    logic shf_q;

    always_ff @(posedge dqs_i or negedge rst_ni) begin
      if (!rst_ni) pos_q <= 1'b0;
      else         pos_q <= dq_i[g];
    end

    // rise bit shifted by half a strobe cycle so it lines up with the fall bit
    always_ff @(negedge dqs_i or negedge rst_ni) begin
      if (!rst_ni) begin
        neg_q <= 1'b0;
        shf_q <= 1'b0;
      end else begin
        neg_q <= dq_i[g];
        shf_q <= pos_q;
      end
    end

    assign rise_o[g] = shf_q;
    assign fall_o[g] = neg_q;
  end

  // pair marker: window flag and a toggle that flips once per completed pair
  always_ff @(negedge dqs_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      vld_q <= preamble_i;
      tog_q <= ~tog_q;
    end
  end

  assign vld_o = vld_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/ddr_sys_xfer.sv
module ddr_sys_xfer
  import ddr_cap_pkg::*;
#(
  parameter int unsigned DQ_W = 1
) (
  input  logic            sys_clk_i,
  input  logic            rst_ni,
  input  logic            full_i,
  input  logic [DQ_W-1:0] rise_i,
  input  logic [DQ_W-1:0] fall_i,
  input  logic            vld_i,
  input  logic            tog_i,
  output logic [DQ_W-1:0] q_rise_o,
  output logic [DQ_W-1:0] q_fall_o,
  output logic            valid_o
);
  xfer_mode_e      mode;
  logic            tog_seen_q;
  logic            fresh;
  logic [DQ_W-1:0] mid_rise_q;
  logic [DQ_W-1:0] mid_fall_q;
  logic            mid_vld_q;
  logic [DQ_W-1:0] out_rise_q;
  logic [DQ_W-1:0] out_fall_q;
  logic            out_vld_q;

  assign mode  = xfer_mode_e'(full_i);
  assign fresh = tog_i ^ tog_seen_q;

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_seen_q <= 1'b0;
      mid_rise_q <= '0;
      mid_fall_q <= '0;
      mid_vld_q  <= 1'b0;
      out_rise_q <= '0;
      out_fall_q <= '0;
      out_vld_q  <= 1'b0;
    end else begin
      tog_seen_q <= tog_i;
      mid_rise_q <= rise_i;
      mid_fall_q <= fall_i;
      mid_vld_q  <= vld_i & fresh;
      if (mode == XFER_FULL) begin
        out_rise_q <= mid_rise_q;
        out_fall_q <= mid_fall_q;
        out_vld_q  <= mid_vld_q;
      end else begin
        out_rise_q <= rise_i;
        out_fall_q <= fall_i;
        out_vld_q  <= vld_i & fresh;
      end
    end
  end

  assign q_rise_o = out_rise_q;
  assign q_fall_o = out_fall_q;
  assign valid_o  = out_vld_q;
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture
  import ddr_cap_pkg::*;
#(
  parameter int unsigned DQ_W = DQ_W_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dqs_i,
  input  logic [DQ_W-1:0] dq_i,
  input  logic            preamble_i,
  input  logic            full_mode_i,
  output logic [DQ_W-1:0] q_rise_o,
  output logic [DQ_W-1:0] q_fall_o,
  output logic            pol_o,
  output logic            valid_o
);
  logic            pol;
  logic            sys_clk;
  logic [DQ_W-1:0] cap_rise;
  logic [DQ_W-1:0] cap_fall;
  logic            cap_vld;
  logic            cap_tog;

  ddr_pol_detect u_pol (
    .preamble_i (preamble_i),
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pol_o      (pol)
  );

  // pol only rises while clk_i is high, so the switch makes a falling edge, not a spurious rise
  assign sys_clk = clk_i ^ pol;

  ddr_edge_capture #(.DQ_W(DQ_W)) u_cap (
    .dqs_i      (dqs_i),
    .rst_ni     (rst_ni),
    .dq_i       (dq_i),
    .preamble_i (preamble_i),
    .rise_o     (cap_rise),
    .fall_o     (cap_fall),
    .vld_o      (cap_vld),
    .tog_o      (cap_tog)
  );

  ddr_sys_xfer #(.DQ_W(DQ_W)) u_xfer (
    .sys_clk_i (sys_clk),
    .rst_ni    (rst_ni),
    .full_i    (full_mode_i),
    .rise_i    (cap_rise),
    .fall_i    (cap_fall),
    .vld_i     (cap_vld),
    .tog_i     (cap_tog),
    .q_rise_o  (q_rise_o),
    .q_fall_o  (q_fall_o),
    .valid_o   (valid_o)
  );

  assign pol_o = pol;
endmodule

// File: rtl/ddr_rd_capture_chk.sv
module ddr_rd_capture_chk #(
  parameter int unsigned DQ_W = 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            dqs_i,
  input logic [DQ_W-1:0] dq_i,
  input logic            full_mode_i,
  input logic            sys_clk,
  input logic [DQ_W-1:0] cap_rise,
  input logic [DQ_W-1:0] cap_fall,
  input logic            cap_vld,
  input logic            cap_tog,
  input logic [DQ_W-1:0] q_rise_o,
  input logic [DQ_W-1:0] q_fall_o,
  input logic            pol_o,
  input logic            valid_o
);
  logic [1:0] n_neg;
  logic [1:0] n_sys;

  always_ff @(negedge dqs_i or negedge rst_ni) begin
    if (!rst_ni)             n_neg <= 2'd0;
    else if (n_neg != 2'd3)  n_neg <= n_neg + 2'd1;
  end

  always_ff @(posedge sys_clk or negedge rst_ni) begin
    if (!rst_ni)             n_sys <= 2'd0;
    else if (n_sys != 2'd3)  n_sys <= n_sys + 2'd1;
  end

  a_r2_fall_capture: assert property (@(negedge dqs_i) disable iff (!rst_ni)
    (n_neg != 2'd0) |-> cap_fall == $past(dq_i));

  a_r3_one_pair_per_edge: assert property (@(negedge dqs_i) disable iff (!rst_ni)
    (n_neg != 2'd0) |-> cap_tog != $past(cap_tog));

  a_r5_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_o |=> pol_o);

  a_r7_half_path: assert property (@(posedge sys_clk) disable iff (!rst_ni)
    (n_sys != 2'd0 && !full_mode_i) |->
      (q_rise_o == $past(cap_rise) && q_fall_o == $past(cap_fall)));

  a_r7_full_path: assert property (@(posedge sys_clk) disable iff (!rst_ni)
    (n_sys >= 2'd2 && full_mode_i) |->
      (q_rise_o == $past(cap_rise, 2) && q_fall_o == $past(cap_fall, 2)));

  a_r8_valid_in_window: assert property (@(posedge sys_clk) disable iff (!rst_ni)
    (n_sys >= 2'd2 && valid_o) |-> ($past(cap_vld) || $past(cap_vld, 2)));
endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.DQ_W(DQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dqs_i       (dqs_i),
  .dq_i        (dq_i),
  .full_mode_i (full_mode_i),
  .sys_clk     (sys_clk),
  .cap_rise    (cap_rise),
  .cap_fall    (cap_fall),
  .cap_vld     (cap_vld),
  .cap_tog     (cap_tog),
  .q_rise_o    (q_rise_o),
  .q_fall_o    (q_fall_o),
  .pol_o       (pol_o),
  .valid_o     (valid_o)
);

// File: tb/ddr_rd_capture_test.sv
`timescale 1ns/100ps
module ddr_rd_capture_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dqs_i = 1'b0;
  logic [0:0] dq_i = 1'b0;
  logic       preamble_i = 1'b0;
  logic       full_mode_i = 1'b0;
  logic [0:0] q_rise_o;
  logic [0:0] q_fall_o;
  logic       pol_o;
  logic       valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ddr_rd_capture #(.DQ_W(1)) uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dqs_i       (dqs_i),
    .dq_i        (dq_i),
    .preamble_i  (preamble_i),
    .full_mode_i (full_mode_i),
    .q_rise_o    (q_rise_o),
    .q_fall_o    (q_fall_o),
    .pol_o       (pol_o),
    .valid_o     (valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // R1: all outputs cleared during and after reset
  task automatic do_reset(input logic full);
    rst_ni      = 1'b0;
    dqs_i       = 1'b0;
    dq_i        = 1'b0;
    preamble_i  = 1'b0;
    full_mode_i = full;
    repeat (2) @(posedge clk_i);
    #1;
    chk({q_rise_o, q_fall_o, pol_o, valid_o} == 4'b0, "R1 in reset",
        int'({q_rise_o, q_fall_o, pol_o, valid_o}), 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk({q_rise_o, q_fall_o, pol_o, valid_o} == 4'b0, "R1 after release",
        int'({q_rise_o, q_fall_o, pol_o, valid_o}), 0);
  endtask

  // one read burst: 16 pairs in the window, then one postamble pair outside it
  task automatic run_burst(input real phase, input logic full, input logic [31:0] pat,
                           output int k0);
    logic       exp_pol;
    logic [1:0] got [16];
    int         nv;
    logic       sr, sf, sv;
    do_reset(full);
    exp_pol = (phase < 2.0);
    k0 = -1;
    nv = 0;
    fork
      begin
        @(posedge clk_i);
        #(phase);
        preamble_i = 1'b1;
        for (int j = 0; j < 16; j++) begin
          dq_i = pat[31-2*j];
          #1 dqs_i = 1'b1;
          #1 dq_i = pat[30-2*j];
          #1 dqs_i = 1'b0;
          #1;
        end
        preamble_i = 1'b0;
        dq_i = 1'b1;
        #1 dqs_i = 1'b1;
        #2 dqs_i = 1'b0;
        #1;
      end
      begin
        for (int i = 0; i < 24; i++) begin
          if (exp_pol) @(negedge clk_i); else @(posedge clk_i);
          #1;
          sr = q_rise_o[0];
          sf = q_fall_o[0];
          sv = valid_o;
          if (sv) begin
            if (k0 < 0) k0 = i;
            if (nv < 16) got[nv] = {sr, sf};
            nv++;
          end
          if (exp_pol) @(posedge clk_i); else @(negedge clk_i);
          #1;
          chk({q_rise_o[0], q_fall_o[0], valid_o} == {sr, sf, sv}, "R6 hold on other edge",
              int'({q_rise_o[0], q_fall_o[0], valid_o}), int'({sr, sf, sv}));
        end
      end
    join
    chk(pol_o == exp_pol, "R4 polarity", int'(pol_o), int'(exp_pol));
    chk(nv == 16, "R3 R8 flagged pair count", nv, 16);
    for (int j = 0; j < 16 && j < nv; j++)
      chk(got[j] == pat[31-2*j -: 2], "R2 pair order", int'(got[j]), int'(pat[31-2*j -: 2]));
    chk(valid_o == 1'b0, "R8 valid clears after drain", int'(valid_o), 0);
  endtask

  task automatic sweep(input logic [31:0] pat);
    int kh, kf;
    for (int p = 0; p < 4; p++) begin
      run_burst(0.5 + p, 1'b0, pat, kh);
      run_burst(0.5 + p, 1'b1, pat, kf);
      chk(kh >= 0, "R7 half mode produces data", kh, 0);
      chk(kf == kh + 1, "R7 full mode adds one transfer edge", kf, kh + 1);
    end
  endtask

  // R5: a later preamble edge at the opposite clock level must not move pol_o
  task automatic sticky_pol();
    do_reset(1'b0);
    @(posedge clk_i);
    #2.5 preamble_i = 1'b1;
    #1;
    chk(pol_o == 1'b0, "R4 low level gives 0", int'(pol_o), 0);
    #6 preamble_i = 1'b0;
    @(posedge clk_i);
    #0.5 preamble_i = 1'b1;
    #2;
    chk(pol_o == 1'b0, "R5 second edge ignored (0)", int'(pol_o), 0);
    do_reset(1'b0);
    @(posedge clk_i);
    #0.5 preamble_i = 1'b1;
    #1;
    chk(pol_o == 1'b1, "R4 high level gives 1", int'(pol_o), 1);
    #6 preamble_i = 1'b0;
    @(posedge clk_i);
    #2.5 preamble_i = 1'b1;
    #2;
    chk(pol_o == 1'b1, "R5 second edge ignored (1)", int'(pol_o), 1);
    chk(valid_o == 1'b0, "R8 no strobe no valid", int'(valid_o), 0);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    do_reset(1'b0);
    sweep(32'hA53C_F096);
    sweep(32'h00FF_5A69);
    sticky_pol();
    report();
  end
endmodule